// File: doc/BRIEF.md
# Hybrid Strict-Priority / Weighted Fair Arbiter

This block picks one winner per cycle among eight request lines, each standing for a traffic class. A programmable split count divides the lines into two sets. Lines whose index is at or above the count are served in strict priority, and the highest requesting index wins. Lines below the count share the rest of the bandwidth by deficit-weighted round robin, and that set is served only in cycles with no strict request.

Every weighted line has a small cost value, and the share a line gets falls as its cost rises. When a weighted line wins, it is charged the length of the granted frame times its cost plus one. The lowest running charge is served next, and a rotating pointer breaks ties. Each cycle in which requests are present yields one single-cycle, one-hot grant, which stands for one frame. The frame length offered in that cycle is the one charged to the winner. The split count and the costs are written through a small configuration port. New values are staged and go live only after a cycle with no request.

Top module: `hybrid_sched_arb`

## Requirements
- R1: `gnt` has at most one bit set. It never grants a line whose `req` bit is low, and it is nonzero in every cycle where `req` is nonzero.
- R2: Lines with index greater than or equal to the active split count are strict. If any of them requests, the highest such index is granted.
- R3: A split count of 0 makes all eight lines strict. A count of 8 or more puts all eight lines in the weighted set.
- R4: A weighted line (index below the split count) is granted only in a cycle where no strict line requests.
- R5: A granted weighted line's charge grows by `frame_len * (cost + 1)`. Among the requesting weighted lines, only those holding the smallest charge may be granted. Charges stay within `(2^LEN_W - 1) * 2^COST_W`.
- R6: Ties among eligible weighted lines go to the first one found by searching upward, with wrap, from a pointer. After each weighted grant, the pointer moves to the line just above the winner.
- R7: With equal frame lengths and costs 0 and 1 on two backlogged weighted lines, the cost-0 line receives two of every three grants.
- R8: A weighted line that does not request holds a charge of zero. After every cycle the charges of requesting weighted lines are rebased so that their minimum is zero. A line that starts requesting therefore competes at the current minimum.
- R9: A configuration write with `cfg_addr` 0 to 7 sets the 5-bit cost of the line with that index. Address 8 sets the split count from the low 4 bits of `cfg_wdata`. Writes to addresses 9 to 15 have no effect.
- R10: Written values go live at the end of a cycle in which `req` is all zero. While requests continue, arbitration keeps using the previous split count and costs.
- R11: After reset the split count is 0, all costs are 0, all charges are 0 and the tie pointer is at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request per traffic class |
| frame_len | input | 8 | Length of the frame granted in this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address: 0-7 cost, 8 split count |
| cfg_wdata | input | 5 | Configuration write data |
| gnt | output | 8 | One-hot grant, combinational from the current inputs |

## Verification
All-lines-requesting and mixed strict-plus-weighted patterns separate strict priority from weighted service and show where the split count sits. Equal-cost backlogs with equal lengths exercise the rotating pointer alone. Unequal costs expose errors in the charge product or in the minimum choice, through the exact grant ratio. Requests that drop and come back test the rebasing of charges. Configuration writes issued during steady traffic, and to unused addresses, show whether a value leaked in early or was stored at all. Long random runs with varying lengths and interleaved writes compare every grant against a reference model.

// File: rtl/hsa_pkg.sv
package hsa_pkg;
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_STRICT = 2'd1,
      SRC_WFQ    = 2'd2
   } win_src_e;
endpackage

// File: rtl/hsa_cfg.sv
module hsa_cfg #(
   parameter int NUM_IN = 8,
   parameter int COST_W = 5,
   parameter int CNT_W  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           busy,
   input  logic                           we,
   input  logic [CNT_W-1:0]               addr,
   input  logic [COST_W-1:0]              wdata,
   output logic [CNT_W-1:0]               act_cnt,
   output logic [NUM_IN-1:0][COST_W-1:0]  act_cost
);
   localparam int IDX_W = $clog2(NUM_IN);

   logic [CNT_W-1:0]              sh_cnt;
   logic [NUM_IN-1:0][COST_W-1:0] sh_cost;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_cnt   <= '0;
         sh_cost  <= '0;
         act_cnt  <= '0;
         act_cost <= '0;
      end else begin
         if (!busy) begin
            act_cnt  <= sh_cnt;
            act_cost <= sh_cost;
         end
         if (we) begin
            if (int'(addr) < NUM_IN)
               sh_cost[addr[IDX_W-1:0]] <= wdata;
            else if (int'(addr) == NUM_IN)
               sh_cnt <= wdata[CNT_W-1:0];
         end
      end
   end

   // live configuration holds while requests keep arriving
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(act_cnt) && $stable(act_cost)));
endmodule

// File: rtl/hsa_strict.sv
module hsa_strict #(
   parameter int NUM_IN = 8,
   parameter int CNT_W  = 4
) (
   input  logic [NUM_IN-1:0] req,
   input  logic [CNT_W-1:0]  cnt,
   output logic [NUM_IN-1:0] gnt,
   output logic              any
);
   always_comb begin
      gnt = '0;
      for (int i = 0; i < NUM_IN; i++) begin
         if (req[i] && (i >= int'(cnt))) begin
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
      any = |gnt;
   end
endmodule

// File: rtl/hsa_dwrr.sv
module hsa_dwrr #(
   parameter int NUM_IN = 8,
   parameter int COST_W = 5,
   parameter int LEN_W  = 8,
   parameter int CNT_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_IN-1:0]             req,
   input  logic [CNT_W-1:0]              cnt,
   input  logic [NUM_IN-1:0][COST_W-1:0] cost,
   input  logic [LEN_W-1:0]              len,
   input  logic                          take,
   output logic [NUM_IN-1:0]             gnt,
   output logic                          any
);
   localparam int IDX_W = $clog2(NUM_IN);
   localparam int CHG_W = LEN_W + COST_W;
   localparam int SUM_W = CHG_W + 1;
   localparam logic [CHG_W-1:0] TMAX = CHG_W'(((1 << LEN_W) - 1) * (1 << COST_W));

   logic [CHG_W-1:0]  chg [NUM_IN];
   logic [CHG_W-1:0]  nxt [NUM_IN];
   logic [SUM_W-1:0]  upd [NUM_IN];
   logic [IDX_W-1:0]  ptr, win;
   logic [NUM_IN-1:0] rq, elig;
   logic [CHG_W-1:0]  minc;
   logic [SUM_W-1:0]  minu, term;

   always_comb begin
      for (int i = 0; i < NUM_IN; i++)
         rq[i] = req[i] && (i < int'(cnt));
      minc = '1;
      for (int i = 0; i < NUM_IN; i++)
         if (rq[i] && chg[i] < minc) minc = chg[i];
      for (int i = 0; i < NUM_IN; i++)
         elig[i] = rq[i] && (chg[i] == minc);
      any = 1'b0;
      win = '0;
      for (int k = 0; k < NUM_IN; k++) begin
         if (!any && elig[(int'(ptr) + k) % NUM_IN]) begin
            any = 1'b1;
            win = IDX_W'((int'(ptr) + k) % NUM_IN);
         end
      end
      gnt = '0;
      if (any) gnt[win] = 1'b1;
   end

   always_comb begin
      term = SUM_W'(len) * (SUM_W'(cost[win]) + SUM_W'(1));
      for (int i = 0; i < NUM_IN; i++)
         upd[i] = SUM_W'(chg[i]) + ((take && any && int'(win) == i) ? term : '0);
      minu = '1;
      for (int i = 0; i < NUM_IN; i++)
         if (rq[i] && upd[i] < minu) minu = upd[i];
      for (int i = 0; i < NUM_IN; i++)
         nxt[i] = rq[i] ? CHG_W'(upd[i] - minu) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < NUM_IN; i++) chg[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_IN; i++) chg[i] <= nxt[i];
         if (take && any)
            ptr <= (int'(win) == NUM_IN - 1) ? '0 : win + IDX_W'(1);
      end
   end

   for (genvar g = 0; g < NUM_IN; g++) begin : g_chk
      assert_charge_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
         chg[g] <= TMAX);
      assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !(req[g] && (g < int'(cnt))) |=> (chg[g] == '0));
   end
endmodule

// File: rtl/hybrid_sched_arb.sv
module hybrid_sched_arb #(
   parameter int NUM_IN = 8,
   parameter int COST_W = 5,
   parameter int LEN_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_IN-1:0]        req,
   input  logic [LEN_W-1:0]         frame_len,
   input  logic                     cfg_we,
   input  logic [$clog2(NUM_IN+1)-1:0] cfg_addr,
   input  logic [COST_W-1:0]        cfg_wdata,
   output logic [NUM_IN-1:0]        gnt
);
   import hsa_pkg::*;

   localparam int CNT_W = $clog2(NUM_IN + 1);

   if (NUM_IN < 2) begin : g_bad_num
      $error("hybrid_sched_arb: NUM_IN must be at least 2");
   end
   if (COST_W < CNT_W) begin : g_bad_cost
      $error("hybrid_sched_arb: COST_W must cover the split count width");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("hybrid_sched_arb: LEN_W must be positive");
   end

   logic [CNT_W-1:0]              act_cnt;
   logic [NUM_IN-1:0][COST_W-1:0] act_cost;
   logic [NUM_IN-1:0]             s_gnt, w_gnt, wmask;
   logic                          s_any, w_any;
   win_src_e                      src;

   hsa_cfg #(.NUM_IN(NUM_IN), .COST_W(COST_W), .CNT_W(CNT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .busy(|req), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .act_cnt(act_cnt), .act_cost(act_cost));

   hsa_strict #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_strict (
      .req(req), .cnt(act_cnt), .gnt(s_gnt), .any(s_any));

   hsa_dwrr #(.NUM_IN(NUM_IN), .COST_W(COST_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dwrr (
      .clk(clk), .rst_n(rst_n), .req(req), .cnt(act_cnt), .cost(act_cost),
      .len(frame_len), .take(!s_any), .gnt(w_gnt), .any(w_any));

   always_comb begin
      if (s_any)      src = SRC_STRICT;
      else if (w_any) src = SRC_WFQ;
      else            src = SRC_NONE;
      case (src)
         SRC_STRICT: gnt = s_gnt;
         SRC_WFQ:    gnt = w_gnt;
         default:    gnt = '0;
      endcase
      for (int i = 0; i < NUM_IN; i++) wmask[i] = (i < int'(act_cnt));
   end

   assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_grant_subset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
   assert_work_conserving_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|gnt));
   assert_strict_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(gnt & wmask)) |-> ((req & ~wmask) == '0));
endmodule

// File: tb/hybrid_sched_arb_test.sv
module hybrid_sched_arb_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req = '0;
   logic [7:0] frame_len = '0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [4:0] cfg_wdata = '0;
   logic [7:0] gnt;

   int errors = 0;
   int checks = 0;
   int m_cnt_sh = 0, m_cnt_act = 0, m_ptr = 0;
   int m_cost_sh[8];
   int m_cost_act[8];
   int m_chg[8];
   int cnt0;

   hybrid_sched_arb uut (.clk(clk), .rst_n(rst_n), .req(req), .frame_len(frame_len),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gnt(gnt));

   always #5 clk = ~clk;

   function automatic int eff_cnt();
      return (m_cnt_act > 8) ? 8 : m_cnt_act;
   endfunction

   function automatic int exp_win(logic [7:0] r);
      int c = eff_cnt();
      int mn = 1 << 30;
      for (int i = 7; i >= c; i--) if (r[i]) return i;
      for (int i = 0; i < c; i++) if (r[i] && m_chg[i] < mn) mn = m_chg[i];
      for (int k = 0; k < 8; k++) begin
         int j = (m_ptr + k) % 8;
         if (j < c && r[j] && m_chg[j] == mn) return j;
      end
      return -1;
   endfunction

   task automatic model_step(logic [7:0] r, int len, logic we, int addr, int data);
      int c = eff_cnt();
      int w = exp_win(r);
      int mn = 1 << 30;
      if (w >= 0 && w < c) begin
         m_chg[w] += len * (m_cost_act[w] + 1);
         m_ptr = (w + 1) % 8;
      end
      for (int i = 0; i < c; i++) if (r[i] && m_chg[i] < mn) mn = m_chg[i];
      for (int i = 0; i < 8; i++) m_chg[i] = (i < c && r[i]) ? m_chg[i] - mn : 0;
      if (r == 0) begin
         m_cnt_act = m_cnt_sh;
         for (int i = 0; i < 8; i++) m_cost_act[i] = m_cost_sh[i];
      end
      if (we) begin
         if (addr < 8) m_cost_sh[addr] = data;
         else if (addr == 8) m_cnt_sh = data & 15;
      end
   endtask

   task automatic cycle(logic [7:0] r, int len, logic we, int addr, int data, string tag);
      int w;
      logic [7:0] e;
      string t;
      @(negedge clk);
      req = r; frame_len = 8'(len); cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = 5'(data);
      #1;
      w = exp_win(r);
      e = (w < 0) ? 8'h00 : 8'(1 << w);
      t = tag;
      if (t == "") t = (w < 0) ? "R1" : ((w >= eff_cnt()) ? "R2" : "R5");
      checks++;
      if (gnt !== e) begin
         errors++;
         $display("FAIL %s: req=%h gnt=%h expected=%h", t, r, gnt, e);
      end
      model_step(r, len, we, addr, data);
   endtask

   task automatic wr(int addr, int data);
      cycle(8'h00, 0, 1'b1, addr, data, "R9");
   endtask

   task automatic check_val(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL R1: watchdog expired, got=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin m_cost_sh[i] = 0; m_cost_act[i] = 0; m_chg[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state, all strict
      cycle(8'h00, 0, 0, 0, 0, "R11");
      cycle(8'hFF, 9, 0, 0, 0, "R3");
      cycle(8'h0F, 9, 0, 0, 0, "R2");
      // R10: write split count while busy; not live yet
      cycle(8'h03, 4, 1, 8, 4, "R10");
      cycle(8'h03, 4, 0, 0, 0, "R10");
      cycle(8'h00, 0, 0, 0, 0, "R10");
      cycle(8'h03, 4, 0, 0, 0, "R10");
      // R4: strict line preempts weighted lines
      cycle(8'h13, 4, 0, 0, 0, "R4");
      cycle(8'h1F, 4, 0, 0, 0, "R4");
      cycle(8'h00, 0, 0, 0, 0, "R4");
      // R6: equal costs, equal lengths, rotating ties
      for (int k = 0; k < 8; k++) cycle(8'h0F, 5, 0, 0, 0, "R6");
      // R3: count 8 puts all lines in the weighted set
      wr(8, 8); cycle(8'h00, 0, 0, 0, 0, "R3");
      for (int k = 0; k < 4; k++) cycle(8'hFF, 3, 0, 0, 0, "R3");
      // R7: cost 0 vs cost 1
      wr(8, 2); wr(0, 0); wr(1, 1); cycle(8'h00, 0, 0, 0, 0, "R7");
      cnt0 = 0;
      for (int k = 0; k < 30; k++) begin
         cycle(8'h03, 10, 0, 0, 0, "R7");
         if (gnt[0]) cnt0++;
      end
      check_val("R7", cnt0, 20);
      // R9: writes to unused addresses leave costs and count unchanged
      wr(12, 31); wr(15, 7); wr(9, 0); cycle(8'h00, 0, 0, 0, 0, "R9");
      cnt0 = 0;
      for (int k = 0; k < 6; k++) begin
         cycle(8'h03, 10, 0, 0, 0, "R9");
         if (gnt[0]) cnt0++;
      end
      check_val("R9", cnt0, 4);
      // R8: a line that drops out and returns competes at the minimum
      cycle(8'h03, 10, 0, 0, 0, "R8");
      cycle(8'h01, 10, 0, 0, 0, "R8");
      cycle(8'h01, 10, 0, 0, 0, "R8");
      for (int k = 0; k < 4; k++) cycle(8'h03, 10, 0, 0, 0, "R8");
      cycle(8'h00, 0, 0, 0, 0, "R8");
      // random traffic with interleaved configuration writes
      void'($urandom(32'd2024));
      for (int k = 0; k < 4000; k++) begin
         logic [7:0] r;
         int sel = $urandom % 16;
         r = (sel == 0) ? 8'h00 : ((sel < 8) ? 8'($urandom & $urandom) : 8'($urandom));
         if ($urandom % 10 == 0)
            cycle(r, $urandom % 256, 1, $urandom % 16, $urandom % 32, "");
         else
            cycle(r, $urandom % 256, 0, 0, 0, "");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule